// File: doc/BRIEF.md
# Monotonic Ratchet Memory Lock Unit

This unit guards a processor's path to protected code flash and to a small lockable secret RAM. It holds a lock level that starts at zero after reset and can only be stepped upward, one level per advance request, up to a ceiling of four. Nothing except a full reset brings the level back down. Boot firmware raises the level as control passes from more trusted to less trusted code. Each step removes rights that the later code must not have.

Every memory request is matched against a fixed map of protected areas. There are three flash segments and four secret-RAM regions. The decision depends on the current level. A flash segment becomes read-only once the level reaches the level that locks it. A secret-RAM region is closed to both reads and writes once the level goes above its index. Addresses outside all protected areas pass with no restriction. The decision is made in the same cycle as the request, so a refused write never reaches the memory strobe.

Top module: `ratchet_lock_unit`

## Requirements
- R1: After reset, `lock_level` is 0 and `adv_error` is 0.
- R2: A cycle with `adv_req` high and `lock_level` below 4 raises `lock_level` by exactly one at the next clock edge. A cycle without `adv_req` leaves `lock_level` unchanged. No input other than reset lowers it.
- R3: A cycle with `adv_req` high while `lock_level` is 4 leaves the level at 4 and sets `adv_error`. `adv_error` then stays at 1 until reset.
- R4: Flash segment A is 0x1000–0x1FFF, segment B is 0x2000–0x3FFF and segment C is 0x4000–0x5FFF. Writes are refused to A at level ≥1, to B at level ≥2 and to C at level 4. Reads of all three are always granted.
- R5: Secret-RAM region k (k = 0..3) is 0x8000 + k·0x100 up to 0x80FF + k·0x100. Both reads and writes to region k are refused when `lock_level` is greater than k.
- R6: Any address outside the segments of R4 and the regions of R5 is granted for read and write at every level.
- R7: For a refused request, `acc_deny` is 1 and `acc_grant`, `mem_rd_en` and `mem_wr_en` are 0, all in the same cycle. For a granted request, `acc_grant` is 1, `acc_deny` is 0, `mem_wr_en` equals `req_write` and `mem_rd_en` equals its inverse.
- R8: A request in the same cycle as an advance is decided against the level held before that clock edge.
- R9: With `req_valid` low, `acc_grant`, `acc_deny`, `mem_rd_en` and `mem_wr_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high device reset; the only way to lower the level |
| adv_req | input | 1 | Request to step the lock level up by one |
| req_valid | input | 1 | A memory access is presented this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 16 | Byte address of the access |
| acc_grant | output | 1 | Access allowed this cycle |
| acc_deny | output | 1 | One-cycle pulse for a refused access |
| mem_rd_en | output | 1 | Read strobe passed to memory |
| mem_wr_en | output | 1 | Write strobe passed to memory, suppressed on refusal |
| lock_level | output | 3 | Current lock level, 0..4 |
| adv_error | output | 1 | Sticky flag: an advance was requested at the ceiling |

## Verification
The hardest case to reach is a request that arrives in the same cycle as an advance. Here the decision must use the old level, while the very next cycle must see the new one. The bench targets this at the thresholds: it writes segment A while stepping from level 0 to level 1, then repeats the write one cycle later, and expects a grant followed by a refusal. It also walks every level from 0 to 4 and sends the full set of boundary addresses at each level. It then advances past the ceiling to reach the sticky error, and applies reset to check that only reset clears it.

// File: rtl/ratchet_pkg.sv
package ratchet_pkg;

    localparam int ADDR_W    = 16;
    localparam int LVL_W     = 3;
    localparam int LEVEL_MAX = 4;
    localparam int NUM_SEG   = 3;
    localparam int NUM_RGN   = 4;
    localparam int IDX_W     = 2;
    localparam int RGN_SHIFT = 8;

    localparam logic [ADDR_W-1:0] RAM_BASE  = 16'h8000;
    localparam logic [ADDR_W-1:0] RAM_LIMIT = RAM_BASE + ADDR_W'(NUM_RGN << RGN_SHIFT);

    typedef logic [LVL_W-1:0] level_t;

    typedef enum logic [1:0] {
        AREA_OPEN  = 2'd0,
        AREA_FLASH = 2'd1,
        AREA_SRAM  = 2'd2
    } area_e;

    typedef struct packed {
        area_e            area;
        logic [IDX_W-1:0] idx;
    } hit_t;

    typedef struct packed {
        logic grant;
        logic deny;
        logic rd_en;
        logic wr_en;
    } verdict_t;

    // Inclusive lower bound of flash segment i.
    function automatic logic [ADDR_W-1:0] seg_lo(input int i);
        case (i)
            0:       return 16'h1000;
            1:       return 16'h2000;
            default: return 16'h4000;
        endcase
    endfunction

    // Exclusive upper bound of flash segment i.
    function automatic logic [ADDR_W-1:0] seg_hi(input int i);
        case (i)
            0:       return 16'h2000;
            1:       return 16'h4000;
            default: return 16'h6000;
        endcase
    endfunction

    // Lowest level at which flash segment idx turns read-only.
    function automatic level_t seg_ro_level(input logic [IDX_W-1:0] idx);
        if (int'(idx) == NUM_SEG - 1) return level_t'(LEVEL_MAX);
        return level_t'(int'(idx) + 1);
    endfunction

endpackage

// File: rtl/ratchet_counter.sv
module ratchet_counter
    import ratchet_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv_req,
    output level_t level_q,
    output logic   err_q
);
    localparam level_t TOP = level_t'(LEVEL_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            err_q   <= 1'b0;
        end else if (adv_req) begin
            if (level_q == TOP) err_q <= 1'b1;
            else                level_q <= level_q + level_t'(1);
        end
    end
endmodule

// File: rtl/ratchet_decoder.sv
module ratchet_decoder
    import ratchet_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit
);
    logic [NUM_SEG-1:0] seg_match;

    generate
        for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
            assign seg_match[g] = (addr >= seg_lo(g)) && (addr < seg_hi(g));
        end
    endgenerate

    logic              in_ram;
    logic [ADDR_W-1:0] ram_off;
    assign in_ram  = (addr >= RAM_BASE) && (addr < RAM_LIMIT);
    assign ram_off = addr - RAM_BASE;

    always_comb begin
        hit.area = AREA_OPEN;
        hit.idx  = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (seg_match[i]) begin
                hit.area = AREA_FLASH;
                hit.idx  = IDX_W'(i);
            end
        end
        if (in_ram) begin
            hit.area = AREA_SRAM;
            hit.idx  = ram_off[RGN_SHIFT +: IDX_W];
        end
    end
endmodule

// File: rtl/ratchet_policy.sv
module ratchet_policy
    import ratchet_pkg::*;
(
    input  logic     valid,
    input  logic     write,
    input  hit_t     hit,
    input  level_t   level,
    output verdict_t verdict
);
    logic allow;

    always_comb begin
        case (hit.area)
            AREA_FLASH: allow = !write || (level < seg_ro_level(hit.idx));
            AREA_SRAM:  allow = (level <= level_t'(hit.idx));
            default:    allow = 1'b1;
        endcase
        verdict.grant = valid && allow;
        verdict.deny  = valid && !allow;
        verdict.wr_en = valid && allow && write;
        verdict.rd_en = valid && allow && !write;
    end
endmodule

// File: rtl/ratchet_lock_unit.sv
module ratchet_lock_unit
    import ratchet_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_req,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              acc_grant,
    output logic              acc_deny,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [LVL_W-1:0]  lock_level,
    output logic              adv_error
);
    level_t   level_q;
    logic     err_q;
    hit_t     hit;
    verdict_t verdict;

    ratchet_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .adv_req (adv_req),
        .level_q (level_q),
        .err_q   (err_q)
    );

    ratchet_decoder u_dec (
        .addr (req_addr),
        .hit  (hit)
    );

    ratchet_policy u_pol (
        .valid   (req_valid),
        .write   (req_write),
        .hit     (hit),
        .level   (level_q),
        .verdict (verdict)
    );

    assign acc_grant  = verdict.grant;
    assign acc_deny   = verdict.deny;
    assign mem_rd_en  = verdict.rd_en;
    assign mem_wr_en  = verdict.wr_en;
    assign lock_level = level_q;
    assign adv_error  = err_q;
endmodule

// File: rtl/ratchet_lock_unit_chk.sv
module ratchet_lock_unit_chk
    import ratchet_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              adv_req,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              acc_grant,
    input logic              acc_deny,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic [LVL_W-1:0]  lock_level,
    input logic              adv_error
);
    logic in_ram;
    assign in_ram = (req_addr >= RAM_BASE) && (req_addr < RAM_LIMIT);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (lock_level == '0) && !adv_error);

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !adv_req |=> lock_level == $past(lock_level));

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (adv_req && lock_level < LVL_W'(LEVEL_MAX)) |=> lock_level == $past(lock_level) + LVL_W'(1));

    a_r3_ceiling: assert property (@(posedge clk) disable iff (rst)
        lock_level <= LVL_W'(LEVEL_MAX));

    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        adv_error |=> adv_error);

    a_r3_sat_err: assert property (@(posedge clk) disable iff (rst)
        (adv_req && lock_level == LVL_W'(LEVEL_MAX)) |=> adv_error && lock_level == LVL_W'(LEVEL_MAX));

    a_r5_top_closed: assert property (@(posedge clk) disable iff (rst)
        (req_valid && in_ram && lock_level == LVL_W'(LEVEL_MAX)) |-> acc_deny);

    a_r6_high_open: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[ADDR_W-1 -: 2] == 2'b11) |-> acc_grant);

    a_r7_deny_blocks: assert property (@(posedge clk) disable iff (rst)
        acc_deny |-> !acc_grant && !mem_wr_en && !mem_rd_en);

    a_r7_strobe_dir: assert property (@(posedge clk) disable iff (rst)
        acc_grant |-> (mem_wr_en == req_write) && (mem_rd_en == !req_write));

    a_r9_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !acc_grant && !acc_deny && !mem_wr_en && !mem_rd_en);
endmodule

bind ratchet_lock_unit ratchet_lock_unit_chk u_chk (.*);

// File: tb/ratchet_lock_unit_tb.sv
module ratchet_lock_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        adv_req;
    logic        req_valid;
    logic        req_write;
    logic [15:0] req_addr;
    logic        acc_grant, acc_deny, mem_rd_en, mem_wr_en;
    logic [2:0]  lock_level;
    logic        adv_error;

    ratchet_lock_unit u_dut (
        .clk(clk), .rst(rst), .adv_req(adv_req), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .acc_grant(acc_grant),
        .acc_deny(acc_deny), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .lock_level(lock_level), .adv_error(adv_error)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [3:0] exp;   // {grant, deny, rd, wr}
        string      tag;
        logic [15:0] addr;
    } item_t;

    item_t q[$];
    event  smp_ev;
    int    errors = 0;
    int    checks = 0;
    int    exp_level = 0;
    bit    exp_err = 0;
    bit    done = 0;

    // Expected permission from the requirements (R4, R5, R6).
    function automatic bit allow_of(input logic [15:0] a, input bit wr, input int lvl);
        if (a >= 16'h1000 && a < 16'h2000) return !wr || lvl < 1;
        if (a >= 16'h2000 && a < 16'h4000) return !wr || lvl < 2;
        if (a >= 16'h4000 && a < 16'h6000) return !wr || lvl < 4;
        if (a >= 16'h8000 && a < 16'h8400) return lvl <= int'((a - 16'h8000) >> 8);
        return 1'b1;
    endfunction

    // Monitor: pops expected items and compares the outputs.
    initial begin
        forever begin
            @(smp_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [3:0] act;
                it  = q.pop_front();
                act = {acc_grant, acc_deny, mem_rd_en, mem_wr_en};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr=%h act=%b exp=%b", it.tag, it.addr, act, it.exp);
                end
            end
        end
    end

    // Driver: presents one cycle of stimulus and queues the expected result.
    task automatic drive(input bit v, input bit wr, input logic [15:0] a, input bit adv, input string tag);
        item_t it;
        bit ok;
        @(negedge clk);
        req_valid = v; req_write = wr; req_addr = a; adv_req = adv;
        ok = allow_of(a, wr, exp_level);
        if (!v) it.exp = 4'b0000;
        else if (ok) it.exp = {1'b1, 1'b0, !wr, wr};
        else it.exp = 4'b0100;
        it.tag = tag; it.addr = a;
        #5;
        q.push_back(it);
        -> smp_ev;
        if (adv) begin
            if (exp_level == 4) exp_err = 1;
            else exp_level++;
        end
    endtask

    task automatic chk_state(input string tag);
        @(negedge clk);
        req_valid = 0; adv_req = 0;
        #5;
        checks++;
        if (lock_level !== 3'(exp_level) || adv_error !== exp_err) begin
            errors++;
            $display("FAIL %s level=%0d err=%b exp level=%0d err=%b",
                     tag, lock_level, adv_error, exp_level, exp_err);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; adv_req = 0; req_valid = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        exp_level = 0; exp_err = 0;
    endtask

    task automatic sweep(input string tag);
        logic [15:0] pts[12] = '{16'h1000, 16'h1FFF, 16'h2000, 16'h3FFF, 16'h4000,
                                 16'h5FFF, 16'h80FF, 16'h8100, 16'h82FF, 16'h8300,
                                 16'h0FFF, 16'h8400};
        for (int i = 0; i < 12; i++) begin
            drive(1, 1, pts[i], 0, {tag, " R4/R5/R6/R7 write"});
            drive(1, 0, pts[i], 0, {tag, " R4/R5/R6/R7 read"});
        end
        drive(1, 1, 16'hC123, 0, {tag, " R6 open high"});
    endtask

    initial begin
        rst = 1; adv_req = 0; req_valid = 0; req_write = 0; req_addr = '0;
        do_reset();
        chk_state("R1 reset");
        drive(0, 1, 16'h1000, 0, "R9 idle");
        sweep("lvl0");
        for (int l = 1; l <= 4; l++) begin
            drive(0, 0, 16'h0, 1, "R2 advance");
            chk_state("R2 step");
            sweep($sformatf("lvl%0d", l));
        end
        drive(0, 0, 16'h0, 0, "R9 idle");
        chk_state("R2 hold");
        drive(1, 1, 16'h0100, 1, "R3 advance at ceiling");
        chk_state("R3 saturate");
        drive(0, 0, 16'h0, 0, "R9 idle");
        chk_state("R3 sticky");
        do_reset();
        chk_state("R1 reset clears");
        // R8: request in the same cycle as an advance uses the old level.
        drive(1, 1, 16'h1004, 1, "R8 old level write A");
        drive(1, 1, 16'h1004, 0, "R8 new level write A");
        drive(1, 0, 16'h8010, 1, "R8 old level region0");
        drive(1, 0, 16'h8010, 0, "R8 new level region0");
        chk_state("R8 level");
        drive(1, 1, 16'h3000, 1, "R8 old level write B");
        drive(1, 1, 16'h3000, 0, "R8 new level write B");
        drive(0, 0, 16'h0, 0, "R9 idle end");
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule